// File: doc/BRIEF.md
# Synchronous Burst Clock and Latency Generator

This block drives the clock pin of an external memory during a synchronous read burst. It divides the system clock by a programmable factor and keeps the memory clock low when no burst runs. The first memory clock period of each burst presents the address. The block then waits a programmable number of memory clock periods and raises a one-cycle capture strobe once per memory clock period, once for each beat of the burst. A one-cycle done pulse closes the burst.

A controller pulses `start_i` while the block is idle. At that pulse the block samples the divide code, the latency code and the beat count and keeps them for the whole burst. All three fields use offset encodings. Divide code N divides by N+1, and the reserved code 0 divides by 2. Latency code N waits N+2 memory clock periods. Beat code N gives N+1 beats. The address phase is always one memory clock period long, whatever hold or setup values might be set elsewhere.

Top module: `burst_clk_gen`

## Requirements
- R1: While `rst_ni` is low, `mem_clk_o`, `addr_vld_o`, `cap_o` and `done_o` are all low.
- R2: During a burst the memory clock period is D system cycles, where D = `div_cfg_i`+1 for codes 1 to 15 and D = 2 for code 0. Each period starts high, and the clock is high for floor(D/2) system cycles and low for the remaining cycles.
- R3: `mem_clk_o` stays low whenever no burst is in progress, including the cycle of the done pulse.
- R4: An idle block accepts a `start_i` pulse on a rising clock edge. The burst starts in the next cycle, and `addr_vld_o` is high for exactly the first D system cycles of the burst.
- R5: Let memory periods be numbered from 0 for the address period, and let L = `lat_cfg_i`+2. The first `cap_o` pulse falls in the last system cycle of period L.
- R6: `cap_o` pulses once in the last system cycle of each period from L to L+B-1, where B = `beats_i`+1. It never pulses at any other time, and never while `mem_clk_o` or `addr_vld_o` is high.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last `cap_o` pulse. The block is idle in that same cycle.
- R8: A `start_i` pulse during a burst is ignored. Changes to `div_cfg_i`, `lat_cfg_i` or `beats_i` during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-burst pulse, accepted only when idle |
| beats_i | input | BEAT_W | Beat count minus one |
| div_cfg_i | input | 4 | Clock divide code (N divides by N+1, 0 divides by 2) |
| lat_cfg_i | input | 4 | First-data latency code (N waits N+2 memory clocks) |
| mem_clk_o | output | 1 | Divided memory clock, low when idle |
| addr_vld_o | output | 1 | Address valid, high for the first memory clock period |
| cap_o | output | 1 | Data-capture strobe, one system cycle per beat |
| done_o | output | 1 | One-cycle pulse marking the end of the burst |

## Verification
The bench targets the reserved divide code, odd factors, the extremes of divide and latency, and a single-beat burst. A wrong reserved-code mapping would give a period of 1 or 17 cycles. A wrong high-time rounding would make odd periods lopsided the other way. An off-by-one in the latency or beat offsets would shift every capture strobe by a whole memory period, or add or drop a beat. The bench also pulses `start_i` and changes the configuration during bursts. A block that restarted or re-read its configuration would then show a second address phase or a new period length partway through the burst.

// File: rtl/burst_clk_pkg.sv
package burst_clk_pkg;
  localparam int CFG_W = 4;
  localparam int LAT_W = CFG_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_LAT  = 2'd2,
    ST_DATA = 2'd3
  } seq_state_e;

  // last phase index of a memory clock period (D-1); reserved code 0 -> D=2
  function automatic logic [CFG_W-1:0] div_last(input logic [CFG_W-1:0] code);
    return (code == '0) ? CFG_W'(1) : code;
  endfunction

  // high time = floor(D/2)
  function automatic logic [CFG_W-1:0] div_half(input logic [CFG_W-1:0] code);
    logic [CFG_W:0] d;
    d = {1'b0, div_last(code)} + LAT_W'(1);
    return d[CFG_W:1];
  endfunction

  // latency periods after the address period: L-1 = code+1
  function automatic logic [LAT_W-1:0] lat_wait(input logic [CFG_W-1:0] code);
    return {1'b0, code} + LAT_W'(1);
  endfunction
endpackage

// File: rtl/burst_clk_div.sv
module burst_clk_div
  import burst_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CFG_W-1:0] div_cfg_i,
  output logic             mem_clk_o,
  output logic             period_end_o
);
  logic [CFG_W-1:0] last_q, half_q, ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= CFG_W'(1);
      half_q <= CFG_W'(1);
      ph_q   <= '0;
    end else if (load_i) begin
      last_q <= div_last(div_cfg_i);
      half_q <= div_half(div_cfg_i);
      ph_q   <= '0;
    end else if (run_i) begin
      ph_q <= (ph_q == last_q) ? '0 : ph_q + CFG_W'(1);
    end
  end

  assign mem_clk_o    = run_i && (ph_q < half_q);
  assign period_end_o = run_i && (ph_q == last_q);
endmodule

// File: rtl/burst_clk_seq.sv
module burst_clk_seq
  import burst_clk_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [CFG_W-1:0]  lat_cfg_i,
  input  logic              period_end_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              addr_vld_o,
  output logic              cap_o,
  output logic              done_o
);
  seq_state_e        st_q;
  logic [LAT_W-1:0]  lat_q;
  logic [BEAT_W-1:0] beat_q;
  logic              done_q;

  assign load_o = start_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          st_q   <= ST_ADDR;
          lat_q  <= lat_wait(lat_cfg_i);
          beat_q <= beats_i;
        end
        ST_ADDR: if (period_end_i) st_q <= ST_LAT;
        ST_LAT: if (period_end_i) begin
          if (lat_q == LAT_W'(1)) st_q <= ST_DATA;
          else lat_q <= lat_q - LAT_W'(1);
        end
        ST_DATA: if (period_end_i) begin
          if (beat_q == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q - BEAT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign addr_vld_o = (st_q == ST_ADDR);
  assign cap_o      = (st_q == ST_DATA) && period_end_i;
  assign done_o     = done_q;
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import burst_clk_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [CFG_W-1:0]  div_cfg_i,
  input  logic [CFG_W-1:0]  lat_cfg_i,
  output logic              mem_clk_o,
  output logic              addr_vld_o,
  output logic              cap_o,
  output logic              done_o
);
  logic load, busy, period_end;

  burst_clk_div u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .run_i        (busy),
    .div_cfg_i    (div_cfg_i),
    .mem_clk_o    (mem_clk_o),
    .period_end_o (period_end)
  );

  burst_clk_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .beats_i      (beats_i),
    .lat_cfg_i    (lat_cfg_i),
    .period_end_i (period_end),
    .load_o       (load),
    .busy_o       (busy),
    .addr_vld_o   (addr_vld_o),
    .cap_o        (cap_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/burst_clk_chk.sv
module burst_clk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic mem_clk_o,
  input logic addr_vld_o,
  input logic cap_o,
  input logic done_o
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_clk_o);  // R3
  AST_ADDR_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_vld_o) |-> $past(start_i));  // R4
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_vld_o) |-> !$past(busy_i));  // R8
  AST_CAP_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (!mem_clk_o && !addr_vld_o && busy_i));  // R6
  AST_DONE_AFTER_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cap_o) && !busy_i));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !(mem_clk_o || addr_vld_o || cap_o || done_o));  // R1
endmodule

bind burst_clk_gen burst_clk_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy),
  .mem_clk_o  (mem_clk_o),
  .addr_vld_o (addr_vld_o),
  .cap_o      (cap_o),
  .done_o     (done_o)
);

// File: tb/burst_clk_gen_test.sv
`timescale 1ns/1ps
module burst_clk_gen_test;
  localparam int BEAT_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              start;
  logic [BEAT_W-1:0] beats;
  logic [3:0]        div_cfg, lat_cfg;
  logic              mem_clk, addr_vld, cap, done;
  int                n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  burst_clk_gen #(.BEAT_W(BEAT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .beats_i(beats),
    .div_cfg_i(div_cfg), .lat_cfg_i(lat_cfg),
    .mem_clk_o(mem_clk), .addr_vld_o(addr_vld), .cap_o(cap), .done_o(done)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_div(int code);
    return (code == 0) ? 2 : code + 1;
  endfunction

  // run one burst; junk=1 also toggles start and config mid-burst (R8)
  task automatic run_burst(int dc, int lc, int bc, bit junk);
    int d, l, b, total;
    d = exp_div(dc); l = lc + 2; b = bc + 1;
    total = (l + b) * d;
    start = 1'b1; div_cfg = 4'(dc); lat_cfg = 4'(lc); beats = BEAT_W'(bc);
    for (int k = 0; k <= total + 1; k++) begin
      int ph, p;
      bit act;
      @(negedge clk);
      act = (k < total);
      ph  = k % d;
      p   = k / d;
      check(act ? "R2" : "R3", "mem_clk", mem_clk, act && (ph < d / 2));
      check(junk ? "R8" : "R4", "addr_vld", addr_vld, act && (p == 0));
      check((p == l) ? "R5" : "R6", "cap", cap, act && (ph == d - 1) && (p >= l));
      check("R7", "done", done, k == total);
      if (junk && k < total) begin
        start   = 1'($urandom % 2);
        div_cfg = 4'($urandom);
        lat_cfg = 4'($urandom);
        beats   = BEAT_W'($urandom);
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; start = 1'b0; beats = '0; div_cfg = '0; lat_cfg = '0;
    repeat (3) @(negedge clk);
    check("R1", "mem_clk", mem_clk, 1'b0);
    check("R1", "addr_vld", addr_vld, 1'b0);
    check("R1", "cap", cap, 1'b0);
    check("R1", "done", done, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    // directed corners
    run_burst(0, 0, 0, 1'b0);    // reserved divide code, min latency, one beat
    run_burst(1, 0, 3, 1'b0);
    run_burst(2, 1, 2, 1'b0);    // odd factor 3
    run_burst(15, 15, 15, 1'b0); // max everything
    run_burst(14, 3, 1, 1'b0);   // odd factor 15
    run_burst(4, 2, 4, 1'b1);    // mid-burst restart attempts
    // constrained random
    for (int i = 0; i < 40; i++) begin
      run_burst(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                1'($urandom % 3 == 0));
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule